// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a clocked model of a 2048 x 8 memory that two independent ports share. Each port has an active-low chip enable, an address, a write strobe, write data and registered read data. Any port can read or write any word at any time. When both ports are enabled and present the same address, an arbiter lets one port proceed. It drives an active-low busy flag to the other port and suppresses that port's writes in the same cycle.

The arbiter uses only enables and addresses. It does not look at whether an access is a read or a write. Priority goes to the port whose request was already held when the collision began. Simultaneous arrival is resolved in favour of the left port. The winner keeps priority for as long as the collision lasts. A mode input selects master behaviour, where the block computes and drives busy. It can also select slave behaviour, where externally supplied busy levels act only as write inhibits, for arrays in which one master decides collisions for several memories sharing an address range.

Top module: `dpr_arb_ram`

## Requirements
- R1: The memory holds 2048 words of 8 bits addressed by 11 bits per port. At each clock an enabled port (chip enable low) captures the addressed word's prior contents into its read data, which is read-before-write. A disabled port holds its read data. If both ports write the same word in one cycle, the right port's data is stored.
- R2: In master mode, while either chip enable is high or the two addresses differ, both busy outputs are high and writes proceed normally.
- R3: In master mode, while both ports are enabled at the same address, exactly one busy output is low. The two busy outputs are never low together.
- R4: When a collision begins and one port's request (enable and address) is unchanged from the previous cycle while the other's changed, the unchanged port wins and the other port's busy goes low in that same cycle.
- R5: When a collision begins and both requests changed in the same cycle, the left port wins, so the right busy is low.
- R6: The winner keeps priority as long as the collision continues. Busy goes high in the first cycle with no collision, and the next collision is arbitrated anew.
- R7: Whether either port reads or writes has no influence on which port is busy.
- R8: A write from a port whose effective busy is low leaves the memory unchanged.
- R9: A busy port's read returns stored data. If the winning port writes the same word in that cycle, the busy port reads the old value.
- R10: In slave mode both busy outputs are high. A low level on a port's busy input blocks that port's writes regardless of the addresses, and reads are unaffected.
- R11: After reset both read data outputs are 0 and both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_mode | input | 1 | 1: compute and drive busy; 0: use busy inputs as write inhibits |
| lt_ce_n | input | 1 | Left chip enable, active low |
| lt_addr | input | 11 | Left address |
| lt_wr | input | 1 | Left write strobe, active high |
| lt_wdata | input | 8 | Left write data |
| lt_rdata | output | 8 | Left registered read data |
| lt_busy_n_o | output | 1 | Left busy flag, active low (master mode) |
| lt_busy_n_i | input | 1 | Left external busy, active low (slave mode) |
| rt_ce_n | input | 1 | Right chip enable, active low |
| rt_addr | input | 11 | Right address |
| rt_wr | input | 1 | Right write strobe, active high |
| rt_wdata | input | 8 | Right write data |
| rt_rdata | output | 8 | Right registered read data |
| rt_busy_n_o | output | 1 | Right busy flag, active low (master mode) |
| rt_busy_n_i | input | 1 | Right external busy, active low (slave mode) |

## Verification
A corrupted priority register appears on the busy outputs in the same cycle. The busy flag moves to the wrong port while a collision persists, or it lingers after the addresses part. A gating fault lets a busy port's write through. That fault shows only when the word is read back, one clock after the read is issued, so the bench reads colliding addresses again soon after each collision. Read-before-write faults appear on the read data one clock after the conflicting write.

// File: rtl/dpr_pkg.sv
// Shared definitions for the dual-port RAM with collision arbitration.
// Assumes two ports only: index 0 is the left port, index 1 the right port.
package dpr_pkg;
    localparam int NUM_PORTS = 2;
    localparam int PORT_LT   = 0;
    localparam int PORT_RT   = 1;

    // Which port holds priority during an ongoing collision.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpr_collision_arb.sv
// Address-match arbiter. It flags a collision when both ports are enabled at
// the same address and picks a winner by arrival order, with left on a tie.
// The winner is kept in a register until the collision ends. Busy flags are
// combinational from the current request plus registered state, so they are
// valid in the cycle a collision first appears.
// Assumes that chip enables are active low and that reads and writes are not
// distinguished.
module dpr_collision_arb
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_lt,
    input  logic [ADDR_W-1:0] addr_lt,
    input  logic              ce_n_rt,
    input  logic [ADDR_W-1:0] addr_rt,
    output logic              hit,
    output logic              busy_n_lt,
    output logic              busy_n_rt
);
    localparam int REQ_W = ADDR_W + 1;

    logic [REQ_W-1:0] req_lt, req_rt;
    logic [REQ_W-1:0] prev_lt_q, prev_rt_q;
    logic             lt_changed, rt_changed;
    logic             lt_wins;
    owner_e           owner_q, owner_d;
    logic             past_ok_q;

    // Pack each port's request as enable plus address.
    always_comb begin
        req_lt = {~ce_n_lt, addr_lt};
        req_rt = {~ce_n_rt, addr_rt};
    end

    // Detect a collision and note which requests changed since last cycle.
    always_comb begin
        hit        = ~ce_n_lt & ~ce_n_rt & (addr_lt == addr_rt);
        lt_changed = (req_lt != prev_lt_q);
        rt_changed = (req_rt != prev_rt_q);
    end

    // Pick the winner: a held owner first, else the earlier arrival, else left.
    always_comb begin
        unique case (owner_q)
            OWN_LEFT:  lt_wins = 1'b1;
            OWN_RIGHT: lt_wins = 1'b0;
            default:   lt_wins = !(lt_changed && !rt_changed);
        endcase
        busy_n_lt = !(hit && !lt_wins);
        busy_n_rt = !(hit && lt_wins);
        if (!hit)
            owner_d = OWN_NONE;
        else if (lt_wins)
            owner_d = OWN_LEFT;
        else
            owner_d = OWN_RIGHT;
    end

    // Register the owner and the previous requests used for arrival order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q   <= OWN_NONE;
            prev_lt_q <= '0;
            prev_rt_q <= '0;
            past_ok_q <= 1'b0;
        end else begin
            owner_q   <= owner_d;
            prev_lt_q <= req_lt;
            prev_rt_q <= req_rt;
            past_ok_q <= 1'b1;
        end
    end

    AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n_lt || busy_n_rt); // R3
    AST_HIT_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (busy_n_lt != busy_n_rt)); // R3
    AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !(~ce_n_lt & ~ce_n_rt & (addr_lt == addr_rt)) |-> (busy_n_lt && busy_n_rt)); // R2
    AST_KEEP_LT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && hit && $past(hit) && !$past(busy_n_rt)) |-> !busy_n_rt); // R6
    AST_KEEP_RT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && hit && $past(hit) && !$past(busy_n_lt)) |-> !busy_n_lt); // R6
    AST_TIE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && hit && !$past(hit)
         && (($past(addr_lt) != addr_lt) || ($past(ce_n_lt) != ce_n_lt))
         && (($past(addr_rt) != addr_rt) || ($past(ce_n_rt) != ce_n_rt)))
        |-> !busy_n_rt); // R5
    AST_EARLY_RT: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && hit && !$past(hit)
         && (($past(addr_lt) != addr_lt) || ($past(ce_n_lt) != ce_n_lt))
         && $stable(addr_rt) && $stable(ce_n_rt))
        |-> !busy_n_lt); // R4
endmodule

// File: rtl/dpr_wr_gate.sv
// Per-port write qualifier. It selects the busy source by mode: the arbiter's
// flag in master mode, or the external busy input in slave mode. A write
// reaches the memory only if the port is enabled and not busy. The busy
// output pin is held high in slave mode.
// Assumes busy levels are active low.
module dpr_wr_gate (
    input  logic master,
    input  logic ce_n,
    input  logic wr,
    input  logic busy_n_calc,
    input  logic busy_n_ext,
    output logic busy_n_pin,
    output logic wr_en,
    output logic rd_en
);
    logic busy_n_eff;

    // Choose the active busy source and gate the write strobe with it.
    always_comb begin
        busy_n_eff = master ? busy_n_calc : busy_n_ext;
        busy_n_pin = master ? busy_n_calc : 1'b1;
        rd_en      = ~ce_n;
        wr_en      = ~ce_n & wr & busy_n_eff;
    end
endmodule

// File: rtl/dpr_mem.sv
// Two-port word array with synchronous writes and registered read-before-write
// reads. Each port's read data is reset to zero and held while the port is
// disabled. Assumes the caller has already gated the writes; if both ports
// write one word in a cycle, the second port's data is stored.
module dpr_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_a,
    input  logic              wr_en_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] wdata_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              rd_en_b,
    input  logic              wr_en_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] wdata_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Apply gated writes; port b is written last so it wins a same-word clash.
    always_ff @(posedge clk) begin
        if (wr_en_a)
            store[addr_a] <= wdata_a;
        if (wr_en_b)
            store[addr_b] <= wdata_b;
    end

    // Capture the prior word contents for each enabled port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= '0;
            rdata_b <= '0;
        end else begin
            if (rd_en_a)
                rdata_a <= store[addr_a];
            if (rd_en_b)
                rdata_b <= store[addr_b];
        end
    end

    AST_RD_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_a && $past(rst_n)) |=> $stable(rdata_a)); // R1
    AST_RD_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en_b && $past(rst_n)) |=> $stable(rdata_b)); // R1
endmodule

// File: rtl/dpr_arb_ram.sv
// Top level of the dual-port RAM with address-match collision arbitration.
// It connects the arbiter, one write gate per port (built in a generate loop)
// and the shared word array. Assumes synchronous active-low reset. The
// external busy inputs are used only in slave mode.
module dpr_arb_ram
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_mode,
    input  logic              lt_ce_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_wr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_busy_n_o,
    input  logic              lt_busy_n_i,
    input  logic              rt_ce_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_wr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_busy_n_o,
    input  logic              rt_busy_n_i
);
    logic                 hit;
    logic [NUM_PORTS-1:0] ce_n_v, wr_v, busy_calc_v, busy_ext_v;
    logic [NUM_PORTS-1:0] busy_pin_v, wr_en_v, rd_en_v;

    // Gather per-port controls into vectors for the generate loop.
    always_comb begin
        ce_n_v[PORT_LT]     = lt_ce_n;
        ce_n_v[PORT_RT]     = rt_ce_n;
        wr_v[PORT_LT]       = lt_wr;
        wr_v[PORT_RT]       = rt_wr;
        busy_ext_v[PORT_LT] = lt_busy_n_i;
        busy_ext_v[PORT_RT] = rt_busy_n_i;
        lt_busy_n_o         = busy_pin_v[PORT_LT];
        rt_busy_n_o         = busy_pin_v[PORT_RT];
    end

    dpr_collision_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_lt   (lt_ce_n),
        .addr_lt   (lt_addr),
        .ce_n_rt   (rt_ce_n),
        .addr_rt   (rt_addr),
        .hit       (hit),
        .busy_n_lt (busy_calc_v[PORT_LT]),
        .busy_n_rt (busy_calc_v[PORT_RT])
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpr_wr_gate u_gate (
            .master      (master_mode),
            .ce_n        (ce_n_v[p]),
            .wr          (wr_v[p]),
            .busy_n_calc (busy_calc_v[p]),
            .busy_n_ext  (busy_ext_v[p]),
            .busy_n_pin  (busy_pin_v[p]),
            .wr_en       (wr_en_v[p]),
            .rd_en       (rd_en_v[p])
        );
    end

    dpr_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en_a (rd_en_v[PORT_LT]),
        .wr_en_a (wr_en_v[PORT_LT]),
        .addr_a  (lt_addr),
        .wdata_a (lt_wdata),
        .rdata_a (lt_rdata),
        .rd_en_b (rd_en_v[PORT_RT]),
        .wr_en_b (wr_en_v[PORT_RT]),
        .addr_b  (rt_addr),
        .wdata_b (rt_wdata),
        .rdata_b (rt_rdata)
    );

    AST_SLAVE_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (lt_busy_n_o && rt_busy_n_o)); // R10
    AST_MASTER_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && hit) |-> !(wr_en_v[PORT_LT] && wr_en_v[PORT_RT])); // R8
endmodule

// File: tb/tb_dpr_arb_ram.sv
// Self-checking bench: a reference model of memory, read data and arbitration
// state is updated from the requirements each clock. Seeded random stimulus is
// mixed with directed collision scenarios.
module tb_dpr_arb_ram;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 11;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          lt_ce_n = 1'b1, rt_ce_n = 1'b1;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic          lt_wr = 1'b0, rt_wr = 1'b0;
    logic [DW-1:0] lt_wdata = '0, rt_wdata = '0;
    logic [DW-1:0] lt_rdata, rt_rdata;
    logic          lt_busy_n_o, rt_busy_n_o;
    logic          lt_busy_n_i = 1'b1, rt_busy_n_i = 1'b1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_ok  [DEPTH];
    logic [DW-1:0] m_rd_lt, m_rd_rt;
    bit            m_rk_lt, m_rk_rt;
    int            m_owner;            // 0 none, 1 left, 2 right
    logic [AW:0]   m_prev_lt, m_prev_rt;
    string         rd_tag = "R11";

    dpr_arb_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .lt_ce_n(lt_ce_n), .lt_addr(lt_addr), .lt_wr(lt_wr), .lt_wdata(lt_wdata),
        .lt_rdata(lt_rdata), .lt_busy_n_o(lt_busy_n_o), .lt_busy_n_i(lt_busy_n_i),
        .rt_ce_n(rt_ce_n), .rt_addr(rt_addr), .rt_wr(rt_wr), .rt_wdata(rt_wdata),
        .rt_rdata(rt_rdata), .rt_busy_n_o(rt_busy_n_o), .rt_busy_n_i(rt_busy_n_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected arbiter result {left busy_n, right busy_n, left wins, hit}.
    function automatic logic [3:0] arb_model(input logic lce, input logic [AW-1:0] la,
                                             input logic rce, input logic [AW-1:0] ra);
        logic h, lw, lchg, rchg;
        h    = !lce && !rce && (la == ra);
        lchg = ({!lce, la} != m_prev_lt);
        rchg = ({!rce, ra} != m_prev_rt);
        if (m_owner == 1)      lw = 1'b1;
        else if (m_owner == 2) lw = 1'b0;
        else                   lw = !(lchg && !rchg);
        return {!(h && !lw), !(h && lw), lw, h};
    endfunction

    // Which requirement a busy check belongs to.
    function automatic string busy_tag(input logic h, input logic lce, input logic [AW-1:0] la,
                                       input logic rce, input logic [AW-1:0] ra);
        logic lchg, rchg;
        lchg = ({!lce, la} != m_prev_lt);
        rchg = ({!rce, ra} != m_prev_rt);
        if (!h)                return "R2";
        if (m_owner != 0)      return "R6";
        if (lchg && rchg)      return "R5";
        return "R4";
    endfunction

    // One clock: check previous reads, drive, check busy, update the model.
    task automatic step(input bit m, input logic lce, input logic [AW-1:0] la, input logic lw,
                        input logic [DW-1:0] ld, input logic rce, input logic [AW-1:0] ra,
                        input logic rw, input logic [DW-1:0] rdv, input logic lbi,
                        input logic rbi, input string tag);
        logic [3:0] a;
        logic       exp_bl, exp_br, inh_l, inh_r, wl, wr;
        string      bt;
        if (m_rk_lt) check(lt_rdata === m_rd_lt, rd_tag, "left rdata", lt_rdata, m_rd_lt);
        if (m_rk_rt) check(rt_rdata === m_rd_rt, rd_tag, "right rdata", rt_rdata, m_rd_rt);
        master_mode = m; lt_ce_n = lce; lt_addr = la; lt_wr = lw; lt_wdata = ld;
        rt_ce_n = rce; rt_addr = ra; rt_wr = rw; rt_wdata = rdv;
        lt_busy_n_i = lbi; rt_busy_n_i = rbi;
        #1;
        a  = arb_model(lce, la, rce, ra);
        bt = m ? busy_tag(a[0], lce, la, rce, ra) : "R10";
        exp_bl = m ? a[3] : 1'b1;
        exp_br = m ? a[2] : 1'b1;
        check(lt_busy_n_o === exp_bl, bt, "left busy", lt_busy_n_o, exp_bl);
        check(rt_busy_n_o === exp_br, bt, "right busy", rt_busy_n_o, exp_br);
        if (m) check(lt_busy_n_o || rt_busy_n_o, "R3", "both busy low", 0, 1);
        inh_l = m ? !a[3] : !lbi;
        inh_r = m ? !a[2] : !rbi;
        wl = !lce && lw && !inh_l;
        wr = !rce && rw && !inh_r;
        @(posedge clk);
        if (!lce) begin m_rd_lt = m_mem[la]; m_rk_lt = m_ok[la]; end
        if (!rce) begin m_rd_rt = m_mem[ra]; m_rk_rt = m_ok[ra]; end
        if (wl) begin m_mem[la] = ld;  m_ok[la] = 1'b1; end
        if (wr) begin m_mem[ra] = rdv; m_ok[ra] = 1'b1; end
        m_owner   = a[0] ? (a[1] ? 1 : 2) : 0;
        m_prev_lt = {!lce, la};
        m_prev_rt = {!rce, ra};
        rd_tag = tag;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000 && !done) begin
                failures++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) m_ok[i] = 1'b0;
        m_rd_lt = '0; m_rd_rt = '0; m_rk_lt = 1'b1; m_rk_rt = 1'b1;
        m_owner = 0; m_prev_lt = '0; m_prev_rt = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset values seen at the ports.
        check(lt_rdata === 8'h00, "R11", "left rdata after reset", lt_rdata, 0);
        check(rt_rdata === 8'h00, "R11", "right rdata after reset", rt_rdata, 0);
        check(lt_busy_n_o === 1'b1, "R11", "left busy after reset", lt_busy_n_o, 1);
        check(rt_busy_n_o === 1'b1, "R11", "right busy after reset", rt_busy_n_o, 1);

        // R1: fill every word from the left port, right port idle.
        for (int i = 0; i < DEPTH; i++)
            step(1, 0, AW'(i), 1, DW'((i * 7 + 3) & 8'hFF), 1, '0, 0, '0, 1, 1, "R1");
        // R1: read back the top and bottom words from the right port.
        step(1, 1, '0, 0, '0, 0, AW'(DEPTH - 1), 0, '0, 1, 1, "R1");
        step(1, 1, '0, 0, '0, 0, AW'(0), 0, '0, 1, 1, "R1");
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R1");

        // R4: left holds address 5, right arrives later and tries to write (R8).
        step(1, 0, 11'd5, 0, '0, 1, '0, 0, '0, 1, 1, "R1");
        step(1, 0, 11'd5, 0, '0, 0, 11'd5, 1, 8'hAA, 1, 1, "R8");
        step(1, 0, 11'd5, 1, 8'h3C, 0, 11'd5, 0, '0, 1, 1, "R9");  // R6, R9
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R9");
        step(1, 1, '0, 0, '0, 0, 11'd5, 0, '0, 1, 1, "R8");       // R2 then readback
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R8");

        // R4 mirrored: right holds, left arrives; R7 left reads, right writes.
        step(1, 1, '0, 0, '0, 0, 11'd9, 0, '0, 1, 1, "R1");
        step(1, 0, 11'd9, 0, '0, 0, 11'd9, 1, 8'h55, 1, 1, "R7");
        step(1, 0, 11'd9, 1, 8'h11, 0, 11'd9, 0, '0, 1, 1, "R9");
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R9");

        // R5: both arrive together; then R6 re-arbitration after a gap.
        step(1, 0, 11'd20, 1, 8'h01, 0, 11'd20, 1, 8'h02, 1, 1, "R8");
        step(1, 0, 11'd20, 0, '0, 0, 11'd20, 0, '0, 1, 1, "R8");
        step(1, 0, 11'd20, 0, '0, 0, 11'd21, 0, '0, 1, 1, "R8");
        step(1, 0, 11'd20, 0, '0, 0, 11'd20, 0, '0, 1, 1, "R6");

        // R10: slave mode, busy inputs inhibit writes; reads unaffected.
        step(0, 0, 11'd30, 1, 8'h77, 0, 11'd31, 1, 8'h88, 0, 1, "R10");
        step(0, 0, 11'd30, 0, '0, 0, 11'd31, 0, '0, 1, 0, "R10");
        step(0, 0, 11'd31, 0, '0, 0, 11'd30, 0, '0, 1, 1, "R10");
        step(0, 1, '0, 0, '0, 0, 11'd40, 1, 8'hC3, 1, 1, "R1");
        step(0, 0, 11'd40, 1, 8'h3C, 0, 11'd40, 1, 8'hC3, 1, 1, "R1");
        step(0, 0, 11'd40, 0, '0, 1, '0, 0, '0, 1, 1, "R1");

        // Seeded random traffic over a small address window to force collisions.
        for (int n = 0; n < 4000; n++) begin
            logic m;
            m = ($urandom % 8) != 0;
            step(m, ($urandom % 4) == 0, AW'($urandom % 4), $urandom % 2, DW'($urandom),
                 ($urandom % 4) == 0, AW'($urandom % 4), $urandom % 2, DW'($urandom),
                 ($urandom % 3) != 0, ($urandom % 3) != 0, m ? "R7" : "R10");
        end
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R1");
        step(1, 1, '0, 0, '0, 1, '0, 0, '0, 1, 1, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule